// File: doc/BRIEF.md
# Teletext Header Mask Filter

This block decides whether one sliced teletext line is kept or dropped, by looking only at the first few header bytes of the line. Each header byte arrives Hamming 8/4 protected; the block decodes it to a four-bit nibble, correcting a single flipped bit, and compares the nibble against two independent programmable filters. Every filter holds one configuration byte per header position: the upper nibble says which bits are compared, the lower nibble gives the value those bits must have.

A line begins with `line_start` raised together with `byte_valid` on its first byte. In the short header mode two header bytes (the magazine-and-row address pair) are compared; in the long header mode five are compared, so the packet type code byte and two more bytes can be filtered too. Once the last compared byte has been taken, the block raises `dec_valid` for exactly one cycle with the accept decision and the per-filter match flags. The two filter results are merged by a selectable function (OR, AND, NOR, NAND). Remaining payload bytes are ignored until the next line start.

The sequencer has four states. ST_IDLE waits after reset; ST_COLLECT takes header bytes; ST_REPORT presents the decision for one cycle; ST_DRAIN ignores the rest of the line. Transitions: ST_IDLE to ST_COLLECT on a start byte; ST_COLLECT to ST_REPORT on the last compared byte, and ST_COLLECT back to ST_COLLECT (restart) on a new start byte; ST_REPORT to ST_COLLECT on a start byte, else to ST_DRAIN; ST_DRAIN to ST_COLLECT on a start byte.

Top module: `tt_hdr_filter`

## Requirements
- R1: A header byte is decoded to the nibble {bit7, bit5, bit3, bit1} (bit1 is the nibble LSB); a byte with one flipped bit is corrected to the original nibble, so 15h, EAh, 49h decode to 0h, Fh, 2h.
- R2: A header byte with two flipped bits is a mismatch for every filter, even one whose mask for that position is zero.
- R3: Filter byte bits [7:4] are the care mask and bits [3:0] the expected nibble; a nibble bit whose mask bit is 0 always matches, and a filter with all masks zero matches every error-free line. Filter f, position b sits at `filt_cfg[(f*5+b)*8 +: 8]`.
- R4: With `hdr_long`=0 only header bytes 0 and 1 are compared; with `hdr_long`=1 bytes 0 to 4 are compared; the mode is taken at the line start byte.
- R5: `dec_valid` is high for exactly one cycle, the cycle after the last compared byte was taken, once per line; later bytes of the same line have no effect.
- R6: `match_flags[f]` is 1 in the decision cycle only if filter f is enabled in `filt_en[f]` and all compared bytes match it; a disabled filter reports 0.
- R7: `comb_sel` over the enabled filters: 0 = accept if any matches, 1 = accept if all match, 2 = accept if none matches, 3 = accept unless all match.
- R8: With no filter enabled, every line whose header completes is accepted, with both flags 0.
- R9: `byte_valid` without a started line gives no decision; a start byte inside a header restarts comparison from that byte; outside the decision cycle `accept` and `match_flags` are 0.
- R10: After reset `dec_valid`, `accept` and `match_flags` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Marks the first byte of a line (with byte_valid) |
| byte_valid | input | 1 | byte_data carries a line byte this cycle |
| byte_data | input | 8 | Hamming 8/4 coded line byte |
| filt_cfg | input | 80 | Mask/pattern bytes, 5 per filter |
| filt_en | input | 2 | Per-filter enable |
| hdr_long | input | 1 | 0: two header bytes compared, 1: five |
| comb_sel | input | 2 | Combining function of the filter results |
| dec_valid | output | 1 | Decision pulse |
| accept | output | 1 | Line kept (valid with dec_valid) |
| match_flags | output | 2 | Per-filter match (valid with dec_valid) |

## Verification
Directed lines reproduce the magazine 8, row 30, type 2 case and its near misses in type code, row and magazine, so the short mode (type ignored) and the long mode (type compared) are told apart on the same bytes. Lines with single-bit errors separate correction from rejection, and lines with double-bit errors inside and outside the compared window show that uncorrectable bytes reject even zero-mask filters but only when they take part. Both filters enabled against a line that matches one or both distinguish all four combining functions, and random configurations with lines biased towards a filter's pattern cover partial mask matches, varying line lengths and trailing bytes.

// File: rtl/thf_pkg.sv
package thf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_REPORT,
        ST_DRAIN
    } thf_state_e;

    typedef enum logic [1:0] {
        CMB_OR   = 2'd0,
        CMB_AND  = 2'd1,
        CMB_NOR  = 2'd2,
        CMB_NAND = 2'd3
    } thf_comb_e;
endpackage

// File: rtl/thf_ham_dec.sv
module thf_ham_dec (
    input  logic [7:0] code,
    output logic [3:0] nib,
    output logic       bad
);
    logic ok_a, ok_b, ok_c, ok_all;
    logic fa, fb, fc;
    logic [3:0] raw;

    always_comb begin
        ok_a   = ^{code[0], code[1], code[5], code[7]};
        ok_b   = ^{code[1], code[2], code[3], code[7]};
        ok_c   = ^{code[1], code[3], code[4], code[5]};
        ok_all = ^code;
        fa     = ~ok_a;
        fb     = ~ok_b;
        fc     = ~ok_c;
        raw    = {code[7], code[5], code[3], code[1]};
        if (ok_all) begin
            // overall parity intact: any failing group means two flips
            nib = raw;
            bad = fa | fb | fc;
        end else begin
            // one flipped bit: the failing groups point at it
            nib = raw ^ {fa & fb & ~fc, fa & ~fb & fc, ~fa & fb & fc, fa & fb & fc};
            bad = 1'b0;
        end
    end
endmodule

// File: rtl/thf_byte_match.sv
module thf_byte_match #(
    parameter int HDR_MAX = 5,
    parameter int IDX_W   = 3
) (
    input  logic [HDR_MAX*8-1:0] cfg,
    input  logic [IDX_W-1:0]     idx,
    input  logic [3:0]           nib,
    input  logic                 bad,
    output logic                 hit
);
    logic [7:0] sel;

    always_comb begin
        sel = 8'h00;
        for (int b = 0; b < HDR_MAX; b++) begin
            if (idx == IDX_W'(b)) sel = cfg[b*8 +: 8];
        end
        hit = !bad && (((nib ^ sel[3:0]) & sel[7:4]) == 4'h0);
    end
endmodule

// File: rtl/thf_seq.sv
module thf_seq
    import thf_pkg::*;
#(
    parameter int HDR_MAX   = 5,
    parameter int HDR_SHORT = 2,
    parameter int NUM_FILT  = 2,
    parameter int IDX_W     = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_start,
    input  logic                byte_valid,
    input  logic                hdr_long,
    input  logic [NUM_FILT-1:0] byte_hit,
    output logic [IDX_W-1:0]    cmp_idx,
    output logic                report,
    output logic [NUM_FILT-1:0] run_match
);
    localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(HDR_MAX - 1);
    localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(HDR_SHORT - 1);

    thf_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q, last_q;
    logic start_byte, last_byte;

    assign start_byte = line_start & byte_valid;
    assign last_byte  = (state_q == ST_COLLECT) && byte_valid && !start_byte
                        && (idx_q == last_q);
    assign cmp_idx    = start_byte ? '0 : idx_q;
    assign report     = (state_q == ST_REPORT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_byte) state_d = ST_COLLECT;
            ST_COLLECT: begin
                if (start_byte)     state_d = ST_COLLECT;
                else if (last_byte) state_d = ST_REPORT;
            end
            ST_REPORT:  state_d = start_byte ? ST_COLLECT : ST_DRAIN;
            ST_DRAIN:   if (start_byte) state_d = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            last_q    <= LAST_SHORT;
            run_match <= '0;
        end else begin
            state_q <= state_d;
            if (start_byte) begin
                idx_q     <= IDX_W'(1);
                last_q    <= hdr_long ? LAST_LONG : LAST_SHORT;
                run_match <= byte_hit;
            end else if (state_q == ST_COLLECT && byte_valid) begin
                idx_q     <= idx_q + IDX_W'(1);
                run_match <= run_match & byte_hit;
            end
        end
    end
endmodule

// File: rtl/thf_combine.sv
module thf_combine
    import thf_pkg::*;
#(
    parameter int NUM_FILT = 2
) (
    input  logic                report,
    input  logic [NUM_FILT-1:0] run_match,
    input  logic [NUM_FILT-1:0] filt_en,
    input  logic [1:0]          comb_sel,
    output logic                dec_valid,
    output logic                accept,
    output logic [NUM_FILT-1:0] match_flags
);
    logic any_hit, all_hit;

    always_comb begin
        any_hit     = |(run_match & filt_en);
        all_hit     = &(run_match | ~filt_en);
        dec_valid   = report;
        accept      = 1'b0;
        match_flags = '0;
        if (report) begin
            match_flags = run_match & filt_en;
            if (filt_en == '0) begin
                accept = 1'b1;
            end else begin
                unique case (thf_comb_e'(comb_sel))
                    CMB_OR:   accept = any_hit;
                    CMB_AND:  accept = all_hit;
                    CMB_NOR:  accept = ~any_hit;
                    CMB_NAND: accept = ~all_hit;
                endcase
            end
        end
    end
endmodule

// File: rtl/tt_hdr_filter.sv
module tt_hdr_filter #(
    parameter int HDR_MAX   = 5,
    parameter int HDR_SHORT = 2,
    parameter int NUM_FILT  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          line_start,
    input  logic                          byte_valid,
    input  logic [7:0]                    byte_data,
    input  logic [NUM_FILT*HDR_MAX*8-1:0] filt_cfg,
    input  logic [NUM_FILT-1:0]           filt_en,
    input  logic                          hdr_long,
    input  logic [1:0]                    comb_sel,
    output logic                          dec_valid,
    output logic                          accept,
    output logic [NUM_FILT-1:0]           match_flags
);
    localparam int IDX_W = $clog2(HDR_MAX + 1);

    logic [3:0]          nib;
    logic                bad;
    logic [IDX_W-1:0]    cmp_idx;
    logic [NUM_FILT-1:0] byte_hit;
    logic [NUM_FILT-1:0] run_match;
    logic                report;

    thf_ham_dec u_dec (
        .code (byte_data),
        .nib  (nib),
        .bad  (bad)
    );

    for (genvar f = 0; f < NUM_FILT; f++) begin : g_filt
        thf_byte_match #(.HDR_MAX(HDR_MAX), .IDX_W(IDX_W)) u_match (
            .cfg (filt_cfg[f*HDR_MAX*8 +: HDR_MAX*8]),
            .idx (cmp_idx),
            .nib (nib),
            .bad (bad),
            .hit (byte_hit[f])
        );
    end

    thf_seq #(
        .HDR_MAX(HDR_MAX), .HDR_SHORT(HDR_SHORT),
        .NUM_FILT(NUM_FILT), .IDX_W(IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .byte_valid (byte_valid),
        .hdr_long   (hdr_long),
        .byte_hit   (byte_hit),
        .cmp_idx    (cmp_idx),
        .report     (report),
        .run_match  (run_match)
    );

    thf_combine #(.NUM_FILT(NUM_FILT)) u_comb (
        .report      (report),
        .run_match   (run_match),
        .filt_en     (filt_en),
        .comb_sel    (comb_sel),
        .dec_valid   (dec_valid),
        .accept      (accept),
        .match_flags (match_flags)
    );
endmodule

// File: rtl/thf_chk.sv
module thf_chk #(
    parameter int HDR_MAX   = 5,
    parameter int HDR_SHORT = 2,
    parameter int NUM_FILT  = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                line_start,
    input logic                byte_valid,
    input logic [NUM_FILT-1:0] filt_en,
    input logic                hdr_long,
    input logic [1:0]          comb_sel,
    input logic                dec_valid,
    input logic                accept,
    input logic [NUM_FILT-1:0] match_flags
);
    logic [7:0] byte_cnt;
    logic       long_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_cnt <= 8'd0;
            long_q   <= 1'b0;
        end else if (line_start && byte_valid) begin
            byte_cnt <= 8'd1;
            long_q   <= hdr_long;
        end else if (byte_valid && byte_cnt != 8'd0 && byte_cnt != 8'hFF) begin
            byte_cnt <= byte_cnt + 8'd1;
        end
    end

    AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid); // R5
    AST_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(byte_valid)); // R5
    AST_HDR_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (byte_cnt == (long_q ? 8'(HDR_MAX) : 8'(HDR_SHORT)))); // R4
    AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!accept && match_flags == '0)); // R9
    AST_DISABLED_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> ((match_flags & ~filt_en) == '0)); // R6
    AST_NONE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && filt_en == '0) |-> accept); // R8
    AST_OR_FUNCTION: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && comb_sel == 2'd0 && filt_en != '0) |-> (accept == (|match_flags))); // R7
endmodule

bind tt_hdr_filter thf_chk #(
    .HDR_MAX(HDR_MAX), .HDR_SHORT(HDR_SHORT), .NUM_FILT(NUM_FILT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_start  (line_start),
    .byte_valid  (byte_valid),
    .filt_en     (filt_en),
    .hdr_long    (hdr_long),
    .comb_sel    (comb_sel),
    .dec_valid   (dec_valid),
    .accept      (accept),
    .match_flags (match_flags)
);

// File: tb/tt_hdr_filter_bench.sv
module tt_hdr_filter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [79:0] filt_cfg;
    logic [1:0]  filt_en = 2'b00;
    logic        hdr_long = 1'b0;
    logic [1:0]  comb_sel = 2'b00;
    logic        dec_valid, accept;
    logic [1:0]  match_flags;

    logic [7:0] cfg   [0:1][0:4];
    logic [3:0] lnib  [0:7];
    int         lflip [0:7];
    logic [7:0] lbyte [0:7];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int f = 0; f < 2; f++)
            for (int b = 0; b < 5; b++)
                filt_cfg[(f*5+b)*8 +: 8] = cfg[f][b];
    end

    tt_hdr_filter u_tt_hdr_filter (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .byte_valid(byte_valid),
        .byte_data(byte_data), .filt_cfg(filt_cfg), .filt_en(filt_en),
        .hdr_long(hdr_long), .comb_sel(comb_sel), .dec_valid(dec_valid),
        .accept(accept), .match_flags(match_flags)
    );

    function automatic logic [7:0] ham_enc(input logic [3:0] d);
        logic p1, p2, p3, p4;
        p1 = ~(d[0] ^ d[2] ^ d[3]);
        p2 = ~(d[0] ^ d[1] ^ d[3]);
        p3 = ~(d[0] ^ d[1] ^ d[2]);
        p4 = ~(p1 ^ d[0] ^ p2 ^ d[1] ^ p3 ^ d[2] ^ d[3]);
        return {d[3], p4, d[2], p3, d[1], p2, d[0], p1};
    endfunction

    task automatic build_bytes();
        for (int b = 0; b < 8; b++) begin
            int p, q;
            lbyte[b] = ham_enc(lnib[b]);
            p = $urandom % 8;
            q = (p + 1 + ($urandom % 7)) % 8;
            if (lflip[b] >= 1) lbyte[b][p] = ~lbyte[b][p];
            if (lflip[b] == 2) lbyte[b][q] = ~lbyte[b][q];
        end
    endtask

    task automatic set_line(input logic [3:0] n0, input logic [3:0] n1, input logic [3:0] n2);
        for (int b = 0; b < 8; b++) begin
            lnib[b]  = 4'($urandom);
            lflip[b] = 0;
        end
        lnib[0] = n0; lnib[1] = n1; lnib[2] = n2;
    endtask

    function automatic logic [1:0] model_flags(input int hl);
        logic [1:0] r;
        for (int f = 0; f < 2; f++) begin
            logic m;
            m = filt_en[f];
            for (int b = 0; b < hl; b++) begin
                if (lflip[b] == 2) m = 1'b0;
                else if (((lnib[b] ^ cfg[f][b][3:0]) & cfg[f][b][7:4]) != 4'h0) m = 1'b0;
            end
            r[f] = m;
        end
        return r;
    endfunction

    function automatic logic model_accept(input logic [1:0] fl);
        logic any_m, all_m;
        any_m = |fl;
        all_m = (fl == filt_en);
        if (filt_en == 2'b00) return 1'b1;
        case (comb_sel)
            2'd0: return any_m;
            2'd1: return all_m;
            2'd2: return ~any_m;
            default: return ~all_m;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_dec(input string req, input bit exp_v, input logic [1:0] efl, input logic eacc);
        chk(req, "dec_valid", 32'(dec_valid), 32'(exp_v));
        if (exp_v) begin
            chk(req, "accept", 32'(accept), 32'(eacc));
            chk(req, "match_flags", 32'(match_flags), 32'(efl));
        end else begin
            chk("R9", "accept idle", 32'(accept), 32'd0);
            chk("R9", "flags idle", 32'(match_flags), 32'd0);
        end
    endtask

    // send nb bytes of the current line; the decision is due after byte hl-1
    task automatic send_line(input string req, input int nb, input bit raw);
        int hl;
        logic [1:0] efl;
        logic eacc;
        hl = hdr_long ? 5 : 2;
        if (!raw) build_bytes();
        efl  = model_flags(hl);
        eacc = model_accept(efl);
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            if (i > 0) check_dec(req, i == hl, efl, eacc);
            line_start = (i == 0);
            byte_valid = 1'b1;
            byte_data  = lbyte[i];
        end
        @(negedge clk);
        check_dec(req, nb == hl, efl, eacc);
        line_start = 1'b0;
        byte_valid = 1'b0;
        @(negedge clk);
        check_dec("R5", 1'b0, 2'b00, 1'b0);
    endtask

    task automatic set_pdc_cfg();
        cfg[0][0] = 8'hF0; cfg[0][1] = 8'hFF; cfg[0][2] = 8'hF2;
        cfg[0][3] = 8'h00; cfg[0][4] = 8'h00;
        for (int b = 0; b < 5; b++) cfg[1][b] = 8'h00;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        set_pdc_cfg();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10", "dec_valid", 32'(dec_valid), 32'd0);
        chk("R10", "accept", 32'(accept), 32'd0);
        chk("R10", "match_flags", 32'(match_flags), 32'd0);

        // R1: literal coded bytes 15h EAh 49h decode to 0,F,2 and match
        filt_en = 2'b01; hdr_long = 1'b1; comb_sel = 2'd0;
        set_line(4'h0, 4'hF, 4'h2);
        build_bytes();
        lbyte[0] = 8'h15; lbyte[1] = 8'hEA; lbyte[2] = 8'h49;
        send_line("R1", 6, 1'b1);

        // R3: wrong type code, wrong row, wrong magazine are discarded
        set_line(4'h0, 4'hF, 4'h1); send_line("R3", 5, 1'b0);
        set_line(4'h1, 4'hE, 4'h2); send_line("R3", 5, 1'b0);
        set_line(4'h5, 4'hF, 4'h2); send_line("R3", 5, 1'b0);

        // R4: short mode ignores the type code byte
        hdr_long = 1'b0;
        set_line(4'h0, 4'hF, 4'h7); send_line("R4", 4, 1'b0);
        // R4: double error past the short window has no effect
        set_line(4'h0, 4'hF, 4'h2); lflip[3] = 2; send_line("R4", 5, 1'b0);

        // R1: single-bit error corrected
        hdr_long = 1'b1;
        set_line(4'h0, 4'hF, 4'h2); lflip[1] = 1; send_line("R1", 5, 1'b0);
        set_line(4'h0, 4'hF, 4'h2); lflip[2] = 1; lflip[0] = 1; send_line("R1", 5, 1'b0);

        // R3: all-zero masks match anything
        filt_en = 2'b10;
        set_line(4'h9, 4'h3, 4'hC); send_line("R3", 5, 1'b0);
        // R2: double error rejects even the zero-mask filter
        set_line(4'h9, 4'h3, 4'hC); lflip[4] = 2; send_line("R2", 5, 1'b0);

        // R6: only enabled filter reports
        set_line(4'h0, 4'hF, 4'h2); send_line("R6", 5, 1'b0);

        // R7: every combining function with one and two matching filters
        filt_en = 2'b11;
        for (int c = 0; c < 4; c++) begin
            comb_sel = 2'(c);
            set_line(4'h0, 4'hF, 4'h2); send_line("R7", 5, 1'b0);
            set_line(4'h3, 4'hF, 4'h2); send_line("R7", 5, 1'b0);
        end

        // R8: no filter enabled accepts every line
        filt_en = 2'b00;
        for (int c = 0; c < 4; c++) begin
            comb_sel = 2'(c);
            set_line(4'h6, 4'h1, 4'h8); lflip[0] = 2; send_line("R8", 5, 1'b0);
        end

        // R5: trailing bytes after the decision are ignored
        filt_en = 2'b01; comb_sel = 2'd0; hdr_long = 1'b0;
        set_line(4'h0, 4'hF, 4'h2); send_line("R5", 8, 1'b0);

        // R9: bytes without a line start give no decision
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check_dec("R9", 1'b0, 2'b00, 1'b0);
            byte_valid = 1'b1;
            byte_data  = ham_enc(4'h0);
        end
        @(negedge clk);
        check_dec("R9", 1'b0, 2'b00, 1'b0);
        byte_valid = 1'b0;

        // R9: restart inside a long header
        hdr_long = 1'b1;
        @(negedge clk);
        line_start = 1'b1; byte_valid = 1'b1; byte_data = ham_enc(4'h7);
        @(negedge clk);
        line_start = 1'b0; byte_data = ham_enc(4'h7);
        @(negedge clk);
        check_dec("R9", 1'b0, 2'b00, 1'b0);
        byte_valid = 1'b0;
        set_line(4'h0, 4'hF, 4'h2); send_line("R9", 5, 1'b0);

        // random configurations and lines
        for (int n = 0; n < 400; n++) begin
            int src;
            for (int f = 0; f < 2; f++)
                for (int b = 0; b < 5; b++)
                    cfg[f][b] = 8'($urandom);
            filt_en  = 2'($urandom);
            comb_sel = 2'($urandom);
            hdr_long = 1'($urandom);
            src = $urandom % 2;
            for (int b = 0; b < 8; b++) begin
                int r;
                lnib[b] = (b < 5 && ($urandom % 4) != 0) ? cfg[src][b][3:0] : 4'($urandom);
                r = $urandom % 12;
                lflip[b] = (r == 0) ? 2 : ((r < 3) ? 1 : 0);
            end
            send_line("R3", (hdr_long ? 5 : 2) + ($urandom % 3), 1'b0);
        end

        finish_run();
    end
endmodule